// File: doc/BRIEF.md
# BCD Clock Calendar Counter

This block keeps time of day and the calendar in eight binary-coded-decimal registers: hundredths, seconds, minutes, hours, day of week, date, month and year. An external prescaler supplies a one-cycle enable at 100 Hz. Each enable advances the hundredths register by one, and carries ripple up through the chain in the same clock edge. Month lengths, leap Februaries, the 12-hour and 24-hour hour formats and the wrap of the day of week are all handled inside the counter.

A host sets the clock by presenting all eight registers at once on a 64-bit load bus with a one-cycle strobe. The live register contents are always visible on a 64-bit read bus. A snapshot strobe copies that bus into a holding register in one edge, so a multi-register carry is never seen half done. The hours register holds its own format bit. The day register holds an oscillator-halt bit and a stored reset-enable bit for use by a neighbouring block.

Top module: `bcd_clock_calendar`

## Requirements
- R1: After reset the registers read year 00, month 01, date 01, day 01, hours 00 in 24-hour format, minutes 00, seconds 00 and hundredths 00, and the snapshot reads all zeros.
- R2: Each `tick` with the clock running increments hundredths in BCD. 99 wraps to 00 and carries into seconds; seconds and minutes wrap 59 to 00 and carry. With neither `tick` nor `load`, no register changes.
- R3: With hours bit 7 at 0 (24-hour format), bits 5:4 hold the tens of hours and bits 3:0 the units. 23 wraps to 00 and carries into day and date.
- R4: With hours bit 7 at 1 (12-hour format), bit 5 is PM (1 = PM) and bits 4:0 are BCD hours counting 12, 01 … 11. The step from 11 to 12 toggles bit 5. Only the step from 11 PM to 12 AM carries into day and date.
- R5: Day bits 2:0 count 1 to 7 and wrap from 7 to 1 on each date carry.
- R6: The date wraps to 01 after 30 in months 04, 06, 09 and 11, and after 31 in months 01, 03, 05, 07, 08, 10 and 12, carrying into the month.
- R7: In month 02 the date wraps after 29 when the year value is divisible by 4, and after 28 otherwise.
- R8: Month 12 wraps to 01 and carries into the year. Year 99 wraps to 00.
- R9: While day bit 5 is 1, `tick` changes no register.
- R10: `load` writes all eight registers at the next edge, even when `tick` is high in the same cycle. Register i occupies bits 8i+7:8i of `load_data` and `now_o`, with 0 = hundredths, 1 = seconds, 2 = minutes, 3 = hours, 4 = day, 5 = date, 6 = month, 7 = year.
- R11: Bits with no function read 0 whatever is loaded: seconds and minutes bit 7, hours bit 6, day bits 7, 6 and 3, date bits 7:6 and month bits 7:5. Day bit 4 (reset enable) is stored and read back unchanged.
- R12: `snap_req` copies `now_o` as it stands in that cycle into `snap_o` at the next edge. Without `snap_req`, `snap_o` holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | 100 Hz advance enable, one cycle wide |
| load | input | 1 | Full register load strobe |
| load_data | input | 64 | Eight BCD registers to load |
| snap_req | input | 1 | Snapshot capture strobe |
| now_o | output | 64 | Live register contents |
| snap_o | output | 64 | Captured snapshot |

## Verification
A `tick` or `load` applied in one cycle is visible on `now_o` right after the next rising edge, and a full carry ripple from hundredths to year completes in that same edge. `snap_o` takes, at that same edge, the `now_o` value from before the edge. The bench drives inputs on the falling edge, updates its model for exactly one edge, and compares both buses a quarter period after the next rising edge, so each result is sampled in the cycle it is due.

// File: rtl/bcd_clock_calendar.sv
module bcd_clock_calendar (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick,
  input  logic        load,
  input  logic [63:0] load_data,
  input  logic        snap_req,
  output logic [63:0] now_o,
  output logic [63:0] snap_o
);

  localparam logic [63:0] KEEP = 64'hFF_1F_3F_37_BF_7F_7F_FF;

  function automatic logic [7:0] inc_bcd(input logic [7:0] v);
    return (v[3:0] == 4'd9) ? {v[7:4] + 4'd1, 4'd0} : {v[7:4], v[3:0] + 4'd1};
  endfunction

  logic [7:0] hs, sc, mn, hr, dy, dt, mo, yr;
  logic [7:0] hr_n, last_day;
  logic [6:0] yb;

  assign now_o = {yr, mo, dt, dy, hr, mn, sc, hs};

  wire run  = tick & ~dy[5];
  wire c_hs = run  & (hs == 8'h99);
  wire c_sc = c_hs & (sc == 8'h59);
  wire c_mn = c_sc & (mn == 8'h59);
  wire h11  = hr[4:0] == 5'h11;
  wire h12  = hr[4:0] == 5'h12;
  wire h23  = hr[5:0] == 6'h23;
  wire c_hr = c_mn & (hr[7] ? (h11 & hr[5]) : h23);
  wire c_dt = c_hr & (dt >= last_day);
  wire c_mo = c_dt & (mo == 8'h12);

  wire [3:0] hu = (hr[3:0] == 4'd9) ? 4'd0 : hr[3:0] + 4'd1;
  wire       tc = hr[3:0] == 4'd9;

  assign yb = {3'b000, yr[7:4]} * 7'd10 + {3'b000, yr[3:0]};
  wire leap = yb[1:0] == 2'b00;

  always_comb begin
    if (hr[7]) begin
      if (h11)      hr_n = {2'b10, ~hr[5], 5'h12};
      else if (h12) hr_n = {2'b10, hr[5], 5'h01};
      else          hr_n = {2'b10, hr[5], hr[4] | tc, hu};
    end else begin
      hr_n = h23 ? 8'h00 : {2'b00, hr[5:4] + {1'b0, tc}, hu};
    end
  end

  always_comb begin
    case (mo)
      8'h02:                      last_day = leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: last_day = 8'h30;
      default:                    last_day = 8'h31;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {yr, mo, dt, dy, hr, mn, sc, hs} <= 64'h00_01_01_01_00_00_00_00;
      snap_o <= '0;
    end else begin
      if (snap_req) snap_o <= now_o;
      if (load) begin
        {yr, mo, dt, dy, hr, mn, sc, hs} <= load_data & KEEP;
      end else begin
        if (run)  hs <= c_hs ? 8'h00 : inc_bcd(hs);
        if (c_hs) sc <= (sc == 8'h59) ? 8'h00 : inc_bcd(sc);
        if (c_sc) mn <= (mn == 8'h59) ? 8'h00 : inc_bcd(mn);
        if (c_mn) hr <= hr_n;
        if (c_hr) begin
          dy <= {2'b00, dy[5:4], 1'b0, (dy[2:0] == 3'd7) ? 3'd1 : dy[2:0] + 3'd1};
          dt <= c_dt ? 8'h01 : inc_bcd(dt);
        end
        if (c_dt) mo <= c_mo ? 8'h01 : inc_bcd(mo);
        if (c_mo) yr <= (yr == 8'h99) ? 8'h00 : inc_bcd(yr);
      end
    end
  end

  a_r10_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> now_o == ($past(load_data) & KEEP));

  a_r9_stop_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && dy[5] && !load) |=> $stable(now_o));

  a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !load) |=> $stable(now_o));

  a_r11_zero_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (now_o & ~KEEP) == 64'd0);

  a_r12_snap_copy: assert property (@(posedge clk) disable iff (!rst_n)
    snap_req |=> snap_o == $past(now_o));

  a_r12_snap_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !snap_req |=> $stable(snap_o));

endmodule

// File: tb/bcd_clock_calendar_bench.sv
module bcd_clock_calendar_bench;

  localparam int CLK_PERIOD = 10;
  localparam logic [63:0] KEEP = 64'hFF_1F_3F_37_BF_7F_7F_FF;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, load = 1'b0, snap_req = 1'b0;
  logic [63:0] load_data = '0;
  logic [63:0] now_o, snap_o;
  logic [63:0] model, exp_snap;
  int n_checks = 0, n_fail = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  bcd_clock_calendar u_bcd_clock_calendar (
    .clk(clk), .rst_n(rst_n), .tick(tick), .load(load), .load_data(load_data),
    .snap_req(snap_req), .now_o(now_o), .snap_o(snap_o)
  );

  function automatic int b2i(input logic [7:0] b);
    return int'(b[7:4]) * 10 + int'(b[3:0]);
  endfunction

  function automatic logic [7:0] i2b(input int v);
    return {4'(v / 10), 4'(v % 10)};
  endfunction

  function automatic int mdays(input int m, input int y);
    if (m == 2) return (y % 4 == 0) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  function automatic logic [63:0] mtick(input logic [63:0] s);
    int hs = b2i(s[7:0]);
    int sc = b2i(s[15:8]);
    int mn = b2i(s[23:16]);
    int dt = b2i(s[47:40]);
    int mo = b2i(s[55:48]);
    int yr = b2i(s[63:56]);
    int dw = int'(s[34:32]);
    int hv;
    bit pm = s[29];
    bit c = 1'b1;
    logic [7:0] hb = s[31:24];
    logic [7:0] t;
    if (s[37]) return s;
    hs++;
    if (hs == 100) hs = 0; else c = 1'b0;
    if (c) begin sc++; if (sc == 60) sc = 0; else c = 1'b0; end
    if (c) begin mn++; if (mn == 60) mn = 0; else c = 1'b0; end
    if (c) begin
      if (s[31]) begin
        hv = b2i({3'b000, s[28:24]});
        if (hv == 11) begin hv = 12; c = pm; pm = ~pm; end
        else begin hv = (hv == 12) ? 1 : hv + 1; c = 1'b0; end
        t = i2b(hv);
        hb = {2'b10, pm, t[4:0]};
      end else begin
        hv = b2i({2'b00, s[29:24]}) + 1;
        if (hv == 24) hv = 0; else c = 1'b0;
        hb = i2b(hv);
      end
    end
    if (c) begin
      dw = (dw == 7) ? 1 : dw + 1;
      if (dt == mdays(mo, yr)) dt = 1; else begin dt++; c = 1'b0; end
    end
    if (c) begin if (mo == 12) mo = 1; else begin mo++; c = 1'b0; end end
    if (c) yr = (yr == 99) ? 0 : yr + 1;
    return {i2b(yr), i2b(mo), i2b(dt), {2'b00, s[37:36], 1'b0, 3'(dw)}, hb, i2b(mn), i2b(sc), i2b(hs)};
  endfunction

  function automatic logic [63:0] rand_state();
    int mo = 1 + int'($urandom % 12);
    int yr = int'($urandom % 100);
    int dt = ($urandom % 3 == 0) ? mdays(mo, yr) : 1 + int'($urandom % 28);
    int hv;
    logic [7:0] hb, t;
    logic [63:0] junk = {$urandom, $urandom} & ~KEEP;
    if ($urandom % 2 == 1) begin
      hv = 1 + int'($urandom % 12);
      t = i2b(hv);
      hb = {2'b10, 1'($urandom), t[4:0]};
    end else begin
      hb = i2b(int'($urandom % 24));
    end
    return {i2b(yr), i2b(mo), i2b(dt), {3'b000, 1'($urandom), 1'b0, 3'(1 + $urandom % 7)}, hb,
            i2b(($urandom % 2 == 1) ? 59 : int'($urandom % 60)),
            i2b(($urandom % 2 == 1) ? 59 : int'($urandom % 60)),
            i2b(90 + int'($urandom % 10))} | (($urandom % 2 == 1) ? junk : 64'd0);
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(input bit tk, input bit ld, input bit sp, input logic [63:0] d, input string tag);
    @(negedge clk);
    tick = tk; load = ld; snap_req = sp; load_data = d;
    if (sp) exp_snap = model;
    if (ld) model = d & KEEP;
    else if (tk) model = mtick(model);
    @(posedge clk);
    #(CLK_PERIOD / 4);
    check(tag, now_o, model);
    if (sp) check({tag, " R12 snapshot"}, snap_o, exp_snap);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'd4242);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    model = 64'h00_01_01_01_00_00_00_00;
    #1;
    check("R1 reset registers", now_o, 64'h00_01_01_01_00_00_00_00);
    check("R1 reset snapshot", snap_o, 64'd0);

    step(0, 0, 0, 64'd0, "R2 idle");
    step(1, 0, 0, 64'd0, "R2 first tick");
    check("R2 hundredths 01", now_o, 64'h00_01_01_01_00_00_00_01);
    step(0, 1, 0, 64'h00_01_01_01_00_00_59_99, "R10 load");
    step(1, 0, 0, 64'd0, "R2 second carry");
    check("R2 minute carry", now_o, 64'h00_01_01_01_00_01_00_00);

    step(0, 1, 0, 64'h99_12_31_07_23_59_59_99, "R10 load");
    step(1, 0, 0, 64'd0, "R8 year end");
    check("R3 R5 R8 rollover", now_o, 64'h00_01_01_01_00_00_00_00);

    step(0, 1, 0, 64'h24_02_28_03_23_59_59_99, "R10 load");
    step(1, 0, 0, 64'd0, "R7 leap");
    check("R7 leap Feb 29", now_o, 64'h24_02_29_04_00_00_00_00);
    step(0, 1, 0, 64'h24_02_29_03_23_59_59_99, "R10 load");
    step(1, 0, 0, 64'd0, "R7 leap end");
    check("R7 leap to Mar", now_o, 64'h24_03_01_04_00_00_00_00);
    step(0, 1, 0, 64'h23_02_28_03_23_59_59_99, "R10 load");
    step(1, 0, 0, 64'd0, "R7 common");
    check("R7 common to Mar", now_o, 64'h23_03_01_04_00_00_00_00);

    step(0, 1, 0, 64'h10_04_30_02_23_59_59_99, "R10 load");
    step(1, 0, 0, 64'd0, "R6 30 day");
    check("R6 Apr 30 end", now_o, 64'h10_05_01_03_00_00_00_00);
    step(0, 1, 0, 64'h10_01_30_02_23_59_59_99, "R10 load");
    step(1, 0, 0, 64'd0, "R6 31 day");
    check("R6 Jan 30 to 31", now_o, 64'h10_01_31_03_00_00_00_00);

    step(0, 1, 0, 64'h10_06_10_02_91_59_59_99, "R10 load");
    step(1, 0, 0, 64'd0, "R4 noon");
    check("R4 11AM to 12PM", now_o, 64'h10_06_10_02_B2_00_00_00);
    step(0, 1, 0, 64'h10_06_10_02_B2_59_59_99, "R10 load");
    step(1, 0, 0, 64'd0, "R4 one PM");
    check("R4 12PM to 1PM", now_o, 64'h10_06_10_02_A1_00_00_00);
    step(0, 1, 0, 64'h10_06_10_02_B1_59_59_99, "R10 load");
    step(1, 0, 0, 64'd0, "R4 midnight");
    check("R4 11PM to 12AM", now_o, 64'h10_06_11_03_92_00_00_00);
    step(0, 1, 0, 64'h10_06_10_02_89_59_59_99, "R10 load");
    step(1, 0, 0, 64'd0, "R4 ten");
    check("R4 9AM to 10AM", now_o, 64'h10_06_10_02_90_00_00_00);
    step(0, 1, 0, 64'h10_06_10_02_19_59_59_99, "R10 load");
    step(1, 0, 0, 64'd0, "R3 twenty");
    check("R3 19 to 20", now_o, 64'h10_06_10_02_20_00_00_00);

    step(0, 1, 0, 64'h10_06_10_22_12_34_56_78, "R10 load");
    for (int i = 0; i < 3; i++) step(1, 0, 0, 64'd0, "R9 halted");
    check("R9 halt holds", now_o, 64'h10_06_10_22_12_34_56_78);
    step(1, 1, 0, 64'h10_06_10_12_12_34_56_78, "R10 load over tick");
    check("R10 load beats tick", now_o, 64'h10_06_10_12_12_34_56_78);
    step(1, 0, 1, 64'd0, "R9 restart");
    check("R12 snapshot before tick", snap_o, 64'h10_06_10_12_12_34_56_78);
    check("R11 reset enable kept", now_o, 64'h10_06_10_12_12_34_56_79);
    step(0, 1, 0, {64{1'b1}}, "R11 junk");
    check("R11 zero bits", now_o, KEEP);
    step(0, 0, 0, 64'd0, "R12 hold");
    check("R12 snapshot held", snap_o, 64'h10_06_10_12_12_34_56_78);

    for (int i = 0; i < 3000; i++) begin
      if ($urandom % 50 == 0) step(1'($urandom % 2), 1, 1'($urandom % 8 == 0), rand_state(), "R10 random load");
      else step(($urandom % 10) < 7, 0, 1'($urandom % 8 == 0), 64'd0, "R2 random run");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule